// File: doc/BRIEF.md
# Split Product Register With Rounding

This block holds the result of a multiplier in four registered parts. The top part is an 8-bit signed byte. Two 16-bit middle partials are kept separately, so that a multiplier array can leave its two partial sums unmerged. The bottom part is a 16-bit word. From these parts the block forms a 40-bit signed product. It also forms a rounded copy in which the bottom 16 bits are cleared after a half-unit bias is added. Both results come straight from the registered parts through combinational logic, so they follow any update on the next clock edge.

The register can be filled in two ways. A full-width load takes a 40-bit value, splits it across the top, first-middle and bottom parts, and always zeroes the second middle partial. A part write puts a 16-bit word into any one part that a select code picks; when the top part is picked, only the bottom 8 bits of the word are kept. If a full load and a part write arrive in the same cycle, the full load wins and the part write is dropped.

All four parts are brought out as ports, so the surrounding datapath can read each one on its own.

Top module: `prod_split_reg`

## Requirements
- R1: A synchronous active-high reset clears all four parts, so `prod_full` and `prod_rnd` are both zero in the cycle after reset.
- R2: `prod_full` equals the top part sign-extended and shifted left by 32, plus ((first middle + second middle) shifted left by 16, OR the bottom part). The two middles are added as unsigned 16-bit values, so a carry out of their sum reaches bit 32.
- R3: `prod_rnd` equals (`prod_full` + 0x7FFF) with bits 15:0 cleared. Its bottom 16 bits are therefore always zero, and it lies within -0x8000..+0x7FFF of `prod_full`.
- R4: A full load (`load_en`=1) stores `load_val[15:0]` in the bottom part, `load_val[31:16]` in the first middle part and `load_val[39:32]` in the top part. The values are visible on the next cycle.
- R5: A full load sets the second middle part to zero, whatever it held before.
- R6: A part write (`wr_en`=1, `load_en`=0) stores `wr_data` into the part chosen by `wr_sel`: 0 = bottom, 1 = first middle, 2 = second middle, 3 = top. The top part keeps only `wr_data[7:0]`, and the other parts are unchanged.
- R7: When neither `load_en` nor `wr_en` is set, all four parts keep their values.
- R8: When `load_en` and `wr_en` are both set, only the full load takes effect.
- R9: Both outputs wrap modulo 2^40. For example, a product of 0x7F_FFFF_FFFF rounds to 0x80_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Full-width load strobe |
| load_val | input | 40 | Value split into the parts on a full load |
| wr_en | input | 1 | Single-part write strobe |
| wr_sel | input | 2 | Part picked by a part write (0 bottom, 1 first middle, 2 second middle, 3 top) |
| wr_data | input | 16 | Data for a part write |
| hi_q | output | 8 | Top part |
| mid_a_q | output | 16 | First middle partial |
| mid_b_q | output | 16 | Second middle partial |
| lo_q | output | 16 | Bottom part |
| prod_full | output | 40 | Combined signed product |
| prod_rnd | output | 40 | Rounded product, bits 15:0 zero |

## Verification
The assertions take for granted that every input is driven to a known value outside reset. They also assume that `wr_sel` matters only while `wr_en` is high. The stimulus keeps to this: strobes are driven every cycle and stay low when idle. Loads and part writes are raised together only in the cycles that exercise load priority. The random part values are chosen so that some middle sums carry out, some top parts are negative, and some bottom parts land on each side of the rounding midpoint.

// File: rtl/prodreg_pkg.sv
package prodreg_pkg;

    localparam int unsigned DEF_HI_W  = 8;
    localparam int unsigned DEF_MID_W = 16;
    localparam int unsigned DEF_LO_W  = 16;

    // Part select code of a single-part write; the numbering is decoded as given
    typedef enum logic [1:0] {
        PART_LO    = 2'd0,
        PART_MID_A = 2'd1,
        PART_MID_B = 2'd2,
        PART_HI    = 2'd3
    } part_sel_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_PART = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [3:0] part_we;   // one-hot, indexed by part_sel_e
    } bank_cmd_t;

endpackage

// File: rtl/prod_cmd_decode.sv
module prod_cmd_decode
    import prodreg_pkg::*;
(
    input  logic      load_en,
    input  logic      wr_en,
    input  part_sel_e wr_sel,
    output bank_cmd_t cmd
);

    // Full load outranks a part write issued in the same cycle
    always_comb begin
        cmd.kind    = OP_HOLD;
        cmd.part_we = '0;
        if (load_en) begin
            cmd.kind = OP_LOAD;
        end else if (wr_en) begin
            cmd.kind    = OP_PART;
            cmd.part_we = 4'b0001 << wr_sel;
        end
    end

endmodule

// File: rtl/prod_part_bank.sv
module prod_part_bank
    import prodreg_pkg::*;
#(
    parameter int unsigned HI_W  = DEF_HI_W,
    parameter int unsigned MID_W = DEF_MID_W,
    parameter int unsigned LO_W  = DEF_LO_W,
    localparam int unsigned PROD_W = HI_W + MID_W + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_cmd_t         cmd,
    input  logic [PROD_W-1:0] load_val,
    input  logic [MID_W-1:0]  wr_data,
    output logic [HI_W-1:0]   hi,
    output logic [MID_W-1:0]  mid_a,
    output logic [MID_W-1:0]  mid_b,
    output logic [LO_W-1:0]   lo
);

    localparam int unsigned MID_LSB = LO_W;
    localparam int unsigned HI_LSB  = LO_W + MID_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi    <= '0;
            mid_a <= '0;
            mid_b <= '0;
            lo    <= '0;
        end else begin
            unique case (cmd.kind)
                OP_LOAD: begin
                    lo    <= load_val[LO_W-1:0];
                    mid_a <= load_val[MID_LSB +: MID_W];
                    hi    <= load_val[HI_LSB +: HI_W];
                    mid_b <= '0;
                end
                OP_PART: begin
                    if (cmd.part_we[PART_LO])    lo    <= wr_data[LO_W-1:0];
                    if (cmd.part_we[PART_MID_A]) mid_a <= wr_data;
                    if (cmd.part_we[PART_MID_B]) mid_b <= wr_data;
                    if (cmd.part_we[PART_HI])    hi    <= wr_data[HI_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/prod_merge.sv
module prod_merge
    import prodreg_pkg::*;
#(
    parameter int unsigned HI_W  = DEF_HI_W,
    parameter int unsigned MID_W = DEF_MID_W,
    parameter int unsigned LO_W  = DEF_LO_W,
    localparam int unsigned PROD_W = HI_W + MID_W + LO_W
) (
    input  logic [HI_W-1:0]   hi,
    input  logic [MID_W-1:0]  mid_a,
    input  logic [MID_W-1:0]  mid_b,
    input  logic [LO_W-1:0]   lo,
    output logic [PROD_W-1:0] full,
    output logic [PROD_W-1:0] rnd
);

    localparam int unsigned      SUM_PAD = PROD_W - (MID_W + 1) - LO_W;
    localparam logic [PROD_W-1:0] BIAS   = (PROD_W'(1) << (LO_W - 1)) - PROD_W'(1);

    logic [MID_W:0]      mid_sum;
    logic [PROD_W-1:0]   hi_term;
    logic [PROD_W-1:0]   mid_term;
    logic [PROD_W-1:0]   biased;

    always_comb begin
        // Unsigned sum keeps the carry into the weight of the top part
        mid_sum  = {1'b0, mid_a} + {1'b0, mid_b};
        // Sign extension above the top part falls outside the 40-bit result
        hi_term  = {hi, {(MID_W + LO_W){1'b0}}};
        mid_term = {{SUM_PAD{1'b0}}, mid_sum, {LO_W{1'b0}}};
        full     = hi_term + (mid_term | {{(PROD_W - LO_W){1'b0}}, lo});
        biased   = full + BIAS;
        rnd      = {biased[PROD_W-1:LO_W], {LO_W{1'b0}}};
    end

endmodule

// File: rtl/prod_split_reg.sv
module prod_split_reg
    import prodreg_pkg::*;
#(
    parameter int unsigned HI_W  = DEF_HI_W,
    parameter int unsigned MID_W = DEF_MID_W,
    parameter int unsigned LO_W  = DEF_LO_W,
    localparam int unsigned PROD_W = HI_W + MID_W + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [PROD_W-1:0] load_val,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [MID_W-1:0]  wr_data,
    output logic [HI_W-1:0]   hi_q,
    output logic [MID_W-1:0]  mid_a_q,
    output logic [MID_W-1:0]  mid_b_q,
    output logic [LO_W-1:0]   lo_q,
    output logic [PROD_W-1:0] prod_full,
    output logic [PROD_W-1:0] prod_rnd
);

    bank_cmd_t cmd;

    prod_cmd_decode u_decode (
        .load_en (load_en),
        .wr_en   (wr_en),
        .wr_sel  (part_sel_e'(wr_sel)),
        .cmd     (cmd)
    );

    prod_part_bank #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (load_val),
        .wr_data  (wr_data),
        .hi       (hi_q),
        .mid_a    (mid_a_q),
        .mid_b    (mid_b_q),
        .lo       (lo_q)
    );

    prod_merge #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_merge (
        .hi    (hi_q),
        .mid_a (mid_a_q),
        .mid_b (mid_b_q),
        .lo    (lo_q),
        .full  (prod_full),
        .rnd   (prod_rnd)
    );

endmodule

// File: rtl/prod_split_reg_chk.sv
module prod_split_reg_chk #(
    parameter int unsigned HI_W  = 8,
    parameter int unsigned MID_W = 16,
    parameter int unsigned LO_W  = 16,
    localparam int unsigned PROD_W = HI_W + MID_W + LO_W
) (
    input logic              clk,
    input logic              rst,
    input logic              load_en,
    input logic [PROD_W-1:0] load_val,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [MID_W-1:0]  wr_data,
    input logic [HI_W-1:0]   hi_q,
    input logic [MID_W-1:0]  mid_a_q,
    input logic [MID_W-1:0]  mid_b_q,
    input logic [LO_W-1:0]   lo_q,
    input logic [PROD_W-1:0] prod_full,
    input logic [PROD_W-1:0] prod_rnd
);

    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (LO_W - 1);
    localparam logic [PROD_W-1:0] SPAN = PROD_W'(1) << LO_W;

    logic [PROD_W-1:0] rnd_offset;
    assign rnd_offset = prod_rnd - prod_full + HALF;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (hi_q == '0 && mid_a_q == '0 && mid_b_q == '0 && lo_q == '0)); // R1

    AST_RND_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        prod_rnd[LO_W-1:0] == '0); // R3

    AST_RND_NEAR: assert property (@(posedge clk) disable iff (rst)
        rnd_offset < SPAN); // R3

    AST_LOAD_SPLIT: assert property (@(posedge clk) disable iff (rst)
        load_en |=> ({hi_q, mid_a_q, lo_q} == $past(load_val))); // R4

    AST_LOAD_CLEARS_MID_B: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (mid_b_q == '0)); // R5

    AST_HI_WRITE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (!load_en && wr_en && wr_sel == 2'd3) |=> (hi_q == $past(wr_data[HI_W-1:0]))); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !wr_en) |=> $stable({hi_q, mid_a_q, mid_b_q, lo_q})); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load_en && wr_en) |=> (lo_q == $past(load_val[LO_W-1:0]))); // R8

endmodule

bind prod_split_reg prod_split_reg_chk #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_val  (load_val),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .hi_q      (hi_q),
    .mid_a_q   (mid_a_q),
    .mid_b_q   (mid_b_q),
    .lo_q      (lo_q),
    .prod_full (prod_full),
    .prod_rnd  (prod_rnd)
);

// File: tb/test_prod_split_reg.sv
module test_prod_split_reg;

    typedef struct {
        logic [39:0] full;
        logic [39:0] rnd;
        logic [7:0]  hi;
        logic [15:0] ma;
        logic [15:0] mb;
        logic [15:0] lo;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [39:0] load_val = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  hi_q;
    logic [15:0] mid_a_q, mid_b_q, lo_q;
    logic [39:0] prod_full, prod_rnd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    exp_t sb[$];

    // reference state
    logic [7:0]  m_hi = '0;
    logic [15:0] m_ma = '0, m_mb = '0, m_lo = '0;

    always #2 clk = ~clk;

    prod_split_reg i_prod_split_reg (
        .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hi_q(hi_q), .mid_a_q(mid_a_q), .mid_b_q(mid_b_q), .lo_q(lo_q),
        .prod_full(prod_full), .prod_rnd(prod_rnd)
    );

    function automatic logic [39:0] ref_full(logic [7:0] h, logic [15:0] a, logic [15:0] b, logic [15:0] l);
        longint v;
        v = longint'($signed(h)) <<< 32;
        v = v + (((longint'(a) + longint'(b)) << 16) | longint'(l));
        return v[39:0];
    endfunction

    function automatic logic [39:0] ref_rnd(logic [39:0] f);
        longint v;
        v = (longint'(f) + 64'sh7FFF) & ~64'shFFFF;
        return v[39:0];
    endfunction

    function automatic exp_t snap(string tag);
        exp_t e;
        e.hi = m_hi; e.ma = m_ma; e.mb = m_mb; e.lo = m_lo;
        e.full = ref_full(m_hi, m_ma, m_mb, m_lo);
        e.rnd  = ref_rnd(e.full);
        e.tag  = tag;
        return e;
    endfunction

    // driver: apply one cycle of stimulus, then queue what the ports must show
    task automatic do_op(input logic ld, input logic [39:0] lv, input logic we,
                         input logic [1:0] sel, input logic [15:0] wd, input string tag);
        @(negedge clk);
        load_en = ld; load_val = lv; wr_en = we; wr_sel = sel; wr_data = wd;
        if (ld) begin
            m_lo = lv[15:0]; m_ma = lv[31:16]; m_hi = lv[39:32]; m_mb = '0;
        end else if (we) begin
            case (sel)
                2'd0: m_lo = wd;
                2'd1: m_ma = wd;
                2'd2: m_mb = wd;
                default: m_hi = wd[7:0];
            endcase
        end
        @(posedge clk);
        #1;
        sb.push_back(snap(tag));
    endtask

    task automatic do_idle(input string tag);
        do_op(1'b0, 40'h0, 1'b0, 2'd0, 16'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load_en = 1'b0; wr_en = 1'b0;
        m_hi = '0; m_ma = '0; m_mb = '0; m_lo = '0;
        @(posedge clk);
        #1;
        sb.push_back(snap("R1"));
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: compare the oldest expected item against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (prod_full !== e.full || prod_rnd !== e.rnd || hi_q !== e.hi ||
                    mid_a_q !== e.ma || mid_b_q !== e.mb || lo_q !== e.lo) begin
                    n_fail++;
                    $display("FAIL %s: full=%h rnd=%h hi=%h ma=%h mb=%h lo=%h expected full=%h rnd=%h hi=%h ma=%h mb=%h lo=%h",
                             e.tag, prod_full, prod_rnd, hi_q, mid_a_q, mid_b_q, lo_q,
                             e.full, e.rnd, e.hi, e.ma, e.mb, e.lo);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        do_idle("R1");

        // R4: full loads, positive and negative
        do_op(1'b1, 40'h12_3456_789A, 1'b0, 2'd0, 16'h0, "R4");
        do_op(1'b1, 40'hFF_8000_8000, 1'b0, 2'd0, 16'h0, "R4");

        // R6: part writes through each select code
        do_op(1'b0, 40'h0, 1'b1, 2'd0, 16'h1111, "R6");
        do_op(1'b0, 40'h0, 1'b1, 2'd1, 16'h2222, "R6");
        do_op(1'b0, 40'h0, 1'b1, 2'd2, 16'h3333, "R6");
        do_op(1'b0, 40'h0, 1'b1, 2'd3, 16'hABCD, "R6");   // top keeps 0xCD

        // R7: idle cycles hold everything
        do_idle("R7");
        do_idle("R7");

        // R5: load with a non-zero second middle
        do_op(1'b1, 40'h01_0203_0405, 1'b0, 2'd0, 16'h0, "R5");

        // R2: carry out of the middle sum into bit 32
        do_op(1'b0, 40'h0, 1'b1, 2'd1, 16'hFFFF, "R2");
        do_op(1'b0, 40'h0, 1'b1, 2'd2, 16'h0001, "R2");
        do_op(1'b0, 40'h0, 1'b1, 2'd3, 16'h00FF, "R2");   // negative top, carry to zero
        do_op(1'b0, 40'h0, 1'b1, 2'd2, 16'hFFFF, "R2");

        // R3: rounding midpoint
        do_op(1'b1, 40'h00_0001_7FFF, 1'b0, 2'd0, 16'h0, "R3");
        do_op(1'b1, 40'h00_0001_8000, 1'b0, 2'd0, 16'h0, "R3");
        do_op(1'b1, 40'h00_0001_8001, 1'b0, 2'd0, 16'h0, "R3");
        do_op(1'b1, 40'hFF_FFFF_8001, 1'b0, 2'd0, 16'h0, "R3");

        // R9: wraparound at 40 bits
        do_op(1'b1, 40'h7F_FFFF_FFFF, 1'b0, 2'd0, 16'h0, "R9");
        do_op(1'b0, 40'h0, 1'b1, 2'd2, 16'hFFFF, "R9");
        do_op(1'b1, 40'hFF_FFFF_FFFF, 1'b0, 2'd0, 16'h0, "R9");

        // R8: load and part write together; load wins
        do_op(1'b0, 40'h0, 1'b1, 2'd2, 16'h5A5A, "R8");
        do_op(1'b1, 40'h44_5555_6666, 1'b1, 2'd2, 16'h7777, "R8");
        do_op(1'b1, 40'h80_0000_0001, 1'b1, 2'd3, 16'h1234, "R8");

        // R1: reset in the middle of operation
        do_reset();

        // R2 R3 R6: random part writes and loads
        for (int i = 0; i < 80; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] == 3'd0)
                do_op(1'b1, {r[31:24], $urandom}, 1'b0, 2'd0, 16'h0, "R2");
            else
                do_op(1'b0, 40'h0, 1'b1, r[4:3], r[31:16], "R2");
        end
        do_idle("R7");

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule